// File: doc/BRIEF.md
# Overflow-Controlled Up-Counter Timer

This block is a free-running up-counter with a default width of 16 bits. It advances by one on each clock cycle where the count-tick input is high, provided the timer is enabled and not halted. Software programs it through a small write port. The port has two targets: a control word and a compare word.

When the counter rolls from its all-ones value to zero, the block decides whether the roll is a real overflow or a clear:

- **Real overflow.** A sticky flag is set and a one-cycle interrupt pulse is raised.
- **Clear.** A roll caused by a compare-match clear or by turning the timer off is a clear. It raises neither the flag nor the interrupt.

An optional stop mode freezes the counter at zero after an overflow. Counting stays frozen until software writes the enable bit to 1 again.

Top module: `ovf_timer`

## Requirements
- R1: The counter advances by one only in a cycle where `countTick` is high, the enable bit is 1 and the timer is not halted. With the timer disabled, ticks leave `count` at zero.
- R2: A tick at the all-ones count rolls `count` to zero. At that same clock edge, `ovfFlag` becomes 1 and `ovfIrq` becomes 1.
- R3: Suppose compare mode (control bit 1) and clear-on-match (control bit 2) are both on, and the compare word (address 1) holds all-ones. Then the roll to zero is a clear: neither `ovfFlag` nor `ovfIrq` is raised.
- R4: With compare mode and clear-on-match on and a compare word below all-ones, a tick while `count` equals the compare word loads zero, with no overflow.
- R5: Writing the control word (address 0) with enable bit 0 clears `count` to zero at the next edge, with no overflow flag or pulse.
- R6: With stop mode on (control bit 3), `count` holds zero after an overflow whatever the ticks do.
- R7: Writing enable bit 1 while halted ends the halt. `count` stays zero in the write cycle and reaches 1 on the next tick.
- R8: Writing enable bit 1 while already counting does not disturb the count; a tick in that cycle still counts.
- R9: `ovfFlag` is sticky. A control write with bit 4 at 0 clears it and bit 4 at 1 keeps it. An overflow in the same cycle as a clearing write leaves it set.
- R10: `ovfIrq` is high for exactly one clock cycle per overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| countTick | input | 1 | Count-clock enable, one count per high cycle |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 1 | 0 selects control word, 1 selects compare word |
| wrData | input | CNT_W | Write data |
| count | output | CNT_W | Current counter value |
| ovfFlag | output | 1 | Sticky overflow flag |
| ovfIrq | output | 1 | One-cycle overflow interrupt pulse |

## Verification
Every output is registered. A tick or a write that is presented before a rising edge shows its effect on `count`, `ovfFlag` and `ovfIrq` at that same edge. The pulse falls at the following edge.

The bench changes inputs on the falling edge and samples 1 ns after each rising edge. Each check therefore reads the result of exactly the cycle it stimulated. To reach the roll-over quickly, the bench instantiates the counter with a 10-bit width.

// File: rtl/ovf_timer_pkg.sv
package ovf_timer_pkg;
  localparam int CTRL_EN   = 0;
  localparam int CTRL_CMP  = 1;
  localparam int CTRL_CLR  = 2;
  localparam int CTRL_STOP = 3;
  localparam int CTRL_FLAG = 4;
  localparam int CTRL_BITS = 5;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_CMP  = 1'b1;

  typedef struct packed {
    logic clearCnt;
    logic incCnt;
    logic loadCmp;
  } strobes_t;
endpackage

// File: rtl/ovf_timer_datapath.sv
module ovf_timer_datapath
  import ovf_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         stb,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] count,
  output logic             atMax,
  output logic             atMatch
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cmpReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (stb.clearCnt) begin
      count <= '0;
    end else if (stb.incCnt) begin
      count <= count + ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpReg <= '0;
    end else if (stb.loadCmp) begin
      cmpReg <= wrData;
    end
  end

  assign atMax   = &count;
  assign atMatch = (count == cmpReg);

  // R2: an increment from all-ones lands on zero
  assert_wrap_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.incCnt && atMax |=> count == '0);

  // R1: an increment below all-ones adds exactly one
  assert_step_one_R1: assert property (@(posedge clk) disable iff (!rstN)
    stb.incCnt && !stb.clearCnt && !atMax |=> count == $past(count) + ONE);
endmodule

// File: rtl/ovf_timer_ctrl.sv
module ovf_timer_ctrl
  import ovf_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             countTick,
  input  logic             wrEn,
  input  logic             wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic             atMax,
  input  logic             atMatch,
  output strobes_t         stb,
  output logic             ovfFlag,
  output logic             ovfIrq
);
  logic enReg, cmpMode, clrMatch, stopMode, halted;
  logic wrCtrl, disableNow, startNow, tickOk, matchClr, ovfEvent;

  assign wrCtrl     = wrEn && (wrAddr == ADDR_CTRL);
  assign disableNow = wrCtrl && !wrData[CTRL_EN] && enReg;
  assign startNow   = wrCtrl && wrData[CTRL_EN] && (!enReg || halted);
  assign tickOk     = countTick && enReg && !halted && !disableNow && !startNow;
  assign matchClr   = cmpMode && clrMatch && atMatch;
  assign ovfEvent   = tickOk && atMax && !matchClr;

  always_comb begin
    stb.clearCnt = disableNow || startNow || (tickOk && matchClr);
    stb.incCnt   = tickOk && !matchClr;
    stb.loadCmp  = wrEn && (wrAddr == ADDR_CMP);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg    <= 1'b0;
      cmpMode  <= 1'b0;
      clrMatch <= 1'b0;
      stopMode <= 1'b0;
    end else if (wrCtrl) begin
      enReg    <= wrData[CTRL_EN];
      cmpMode  <= wrData[CTRL_CMP];
      clrMatch <= wrData[CTRL_CLR];
      stopMode <= wrData[CTRL_STOP];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halted  <= 1'b0;
      ovfFlag <= 1'b0;
      ovfIrq  <= 1'b0;
    end else begin
      if (ovfEvent && stopMode) halted <= 1'b1;
      else if (wrCtrl)          halted <= 1'b0;
      if (ovfEvent)                           ovfFlag <= 1'b1;
      else if (wrCtrl && !wrData[CTRL_FLAG])  ovfFlag <= 1'b0;
      ovfIrq <= ovfEvent;
    end
  end

  assert_irq_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    ovfIrq |=> !ovfIrq);

  assert_irq_sets_flag_R2: assert property (@(posedge clk) disable iff (!rstN)
    ovfIrq |-> ovfFlag);

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ovfFlag) |-> $past(wrCtrl && !wrData[CTRL_FLAG]));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    tickOk && matchClr |=> !ovfIrq);

  assert_disable_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    disableNow |=> !ovfIrq && !enReg);

  assert_restart_R7: assert property (@(posedge clk) disable iff (!rstN)
    startNow |=> !halted && enReg);
endmodule

// File: rtl/ovf_timer.sv
module ovf_timer
  import ovf_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             countTick,
  input  logic             wrEn,
  input  logic             wrAddr,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] count,
  output logic             ovfFlag,
  output logic             ovfIrq
);
  strobes_t stb;
  logic atMax, atMatch;

  initial begin
    if (CNT_W < CTRL_BITS) $error("CNT_W too small for control word");
  end

  ovf_timer_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .countTick(countTick), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .atMax(atMax), .atMatch(atMatch),
    .stb(stb), .ovfFlag(ovfFlag), .ovfIrq(ovfIrq)
  );

  ovf_timer_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .count(count), .atMax(atMax), .atMatch(atMatch)
  );
endmodule

// File: tb/ovf_timer_bench.sv
module ovf_timer_bench;
  localparam int W = 10;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic countTick = 1'b0;
  logic wrEn = 1'b0;
  logic wrAddr = 1'b0;
  logic [W-1:0] wrData = '0;
  logic [W-1:0] count;
  logic ovfFlag, ovfIrq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ovf_timer #(.CNT_W(W)) u_ovf_timer (
    .clk(clk), .rstN(rstN), .countTick(countTick), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .count(count),
    .ovfFlag(ovfFlag), .ovfIrq(ovfIrq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic tk);
    @(negedge clk);
    countTick = tk; wrEn = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1);
  endtask

  task automatic wr(input logic a, input int d, input logic tk);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = W'(d); countTick = tk;
    @(posedge clk); #1;
    @(negedge clk);
    wrEn = 1'b0; countTick = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reset count", int'(count), 0);
    check("R2 reset flag", int'(ovfFlag), 0);
    check("R10 reset irq", int'(ovfIrq), 0);
    ticks(4);
    check("R1 disabled ticks", int'(count), 0);
  endtask

  task automatic t_basic();
    wr(1'b0, 'h11, 1'b0);
    ticks(2); cyc(1'b0); ticks(3); cyc(1'b0); cyc(1'b0);
    check("R1 count ticks only", int'(count), 5);
    wr(1'b0, 'h11, 1'b1);
    check("R8 reenable keeps count", int'(count), 6);
    ticks(1);
    check("R8 continue", int'(count), 7);
    wr(1'b0, 'h10, 1'b1);
    check("R5 disable clears", int'(count), 0);
    check("R5 no irq", int'(ovfIrq), 0);
    check("R5 no flag", int'(ovfFlag), 0);
  endtask

  task automatic t_overflow();
    wr(1'b0, 'h11, 1'b0);
    ticks(MAXV);
    check("R2 at max", int'(count), MAXV);
    check("R2 no irq before wrap", int'(ovfIrq), 0);
    ticks(1);
    check("R2 wrap count", int'(count), 0);
    check("R2 flag", int'(ovfFlag), 1);
    check("R2 irq", int'(ovfIrq), 1);
    cyc(1'b0);
    check("R10 irq one cycle", int'(ovfIrq), 0);
    check("R9 flag sticky", int'(ovfFlag), 1);
    wr(1'b0, 'h11, 1'b0);
    check("R9 keep bit", int'(ovfFlag), 1);
    wr(1'b0, 'h01, 1'b0);
    check("R9 clear", int'(ovfFlag), 0);
    ticks(MAXV);
    wr(1'b0, 'h01, 1'b1);
    check("R9 overflow beats clear", int'(ovfFlag), 1);
    check("R9 irq", int'(ovfIrq), 1);
  endtask

  task automatic t_match_max();
    wr(1'b0, 'h00, 1'b0);
    wr(1'b1, MAXV, 1'b0);
    wr(1'b0, 'h07, 1'b0);
    ticks(MAXV);
    check("R3 at max", int'(count), MAXV);
    ticks(1);
    check("R3 cleared", int'(count), 0);
    check("R3 no irq", int'(ovfIrq), 0);
    check("R3 no flag", int'(ovfFlag), 0);
  endtask

  task automatic t_match_low();
    wr(1'b0, 'h00, 1'b0);
    wr(1'b1, 5, 1'b0);
    wr(1'b0, 'h07, 1'b0);
    ticks(5);
    check("R4 at compare", int'(count), 5);
    ticks(1);
    check("R4 clear on match", int'(count), 0);
    check("R4 no irq", int'(ovfIrq), 0);
    ticks(1);
    check("R4 counts on", int'(count), 1);
  endtask

  task automatic t_stop();
    wr(1'b0, 'h00, 1'b0);
    wr(1'b0, 'h09, 1'b0);
    ticks(MAXV + 1);
    check("R6 wrap", int'(count), 0);
    check("R6 irq", int'(ovfIrq), 1);
    ticks(3);
    check("R6 halted holds", int'(count), 0);
    wr(1'b0, 'h19, 1'b1);
    check("R7 zero in write cycle", int'(count), 0);
    ticks(1);
    check("R7 resumes", int'(count), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    t_reset();
    t_basic();
    t_overflow();
    t_match_max();
    t_match_low();
    t_stop();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule